// File: doc/BRIEF.md
# Flash Interrupt and Status Controller

This block keeps the interrupt bookkeeping of a flash memory device. It holds a controller status register with four error flags, an interrupt status register with a master flag and four completion flags, and two system configuration registers. A 16-bit register bus reaches all of them. The command engine, which is not part of this block, reports each finished operation with a one-cycle pulse. A pulse can carry an error qualifier. A separate pulse reports an unrecognised command code. The block sets the matching flags and drives an interrupt pin whose polarity is programmable. It also drives a ready pin that software controls. The block decides whether a command written on the bus is passed to the engine.

The master interrupt flag is kept by a two-state machine. In `ST_FLAGGED` the master flag reads as 1 and command writes are refused. In `ST_ARMED` the master flag reads as 0 and commands are accepted. The machine has these transitions:
- `FLAG_ON_EVENT`: any event pulse or a warm reset moves the machine to `ST_FLAGGED`.
- `CLEAR_BY_WRITE`: in `ST_FLAGGED`, a write to the interrupt register with bit 15 clear and no event pulse in the same cycle moves the machine to `ST_ARMED`.
- `HOLD`: in every other case the machine keeps its state.

A cold reset leaves the machine in `ST_FLAGGED`.

The block has five register addresses on a 3-bit bus address:

| Address | Register |
|---|---|
| 0 | status, read-only |
| 1 | interrupt status |
| 2 | configuration 1 |
| 3 | configuration 2 |
| 4 | command |

Reads of addresses 5 to 7 return 0. Read data is combinational from the current register contents. A write takes effect at the clock edge on which `bus_wr_i` is sampled high.

Top module: `flash_irq_ctrl`

## Requirements
- R1: After cold reset (`rst_ni` low), the registers read as follows:
  - interrupt status reads 0x8080;
  - status reads 0x0000;
  - configuration 1 reads 0x40C0;
  - configuration 2 reads 0x0000;
  - `ready_o` is 1;
  - `cmd_valid_o` is 0.
- R2: A cycle with `warm_rst_i` high loads the registers as follows, ahead of any bus write or event in that cycle:
  - interrupt status becomes 0x8010;
  - status becomes 0x0000;
  - configuration 1 becomes 0x40C0;
  - configuration 2 becomes 0x0000;
  - `ready_o` becomes 1.
- R3: A pulse on `ev_done_i[i]` (i = 0 reset, 1 erase, 2 program, 3 load) sets interrupt status bit 4+i and bit 15. If `ev_err_i` is high in the same cycle, the pulse also sets the following status bits:
  - bit 10 (command error) in every case;
  - bit 10+i as well, for i = 1, 2 or 3.
- R4: A pulse on `ev_unknown_i` sets status bit 10 and interrupt status bit 15.
- R5: A write to the interrupt register ANDs the written value into bits 15 and 7..4. If bit 15 ends up clear, status bits 13..10 are cleared.
- R6: When an event pulse and an interrupt-register write fall in the same cycle, the bits set by the event survive the AND, and bit 15 stays set, so the error flags are kept.
- R7: `irq_o` equals interrupt status bit 15 XOR NOT configuration-1 bit 6, at all times.
- R8: A write to configuration 1 sets `ready_o` to bit 7 of the written value from the next cycle on. Configuration 1 reads back masked with 0xFFE0. Configuration 2 reads back unmasked.
- R9: A command write is accepted only while interrupt status bit 15 is clear. On acceptance, `cmd_valid_o` is high for the single cycle after the write, `cmd_code_o` carries the written value, and the command register reads it back. A refused write leaves both the outputs and the stored code unchanged.
- R10: Writes to the status address change nothing, and reads of addresses 5 to 7 return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Cold reset, asynchronous, active low |
| warm_rst_i | input | 1 | Synchronous warm/hot reset request |
| bus_wr_i | input | 1 | Register write strobe |
| bus_addr_i | input | 3 | Register address for reads and writes |
| bus_wdata_i | input | 16 | Write data |
| bus_rdata_o | output | 16 | Read data of the addressed register |
| ev_done_i | input | 4 | Completion pulses: reset, erase, program, load |
| ev_err_i | input | 1 | Marks the completion pulse of this cycle as failed |
| ev_unknown_i | input | 1 | Unrecognised command pulse |
| irq_o | output | 1 | Interrupt pin with programmable polarity |
| ready_o | output | 1 | Ready pin, set from configuration-1 bit 7 |
| cmd_valid_o | output | 1 | One-cycle strobe for an accepted command |
| cmd_code_o | output | 16 | Last accepted command code |

## Verification
The interesting collision is an event pulse from the command engine landing in the same cycle as a software write to the interrupt register. Such a write, taken alone, would wipe the completion bits, drop the master flag and clear the error flags. The bench drives the event inputs and the bus write on one falling edge and leaves both for exactly one rising edge. It first uses a cleared register, then a register that already holds an error. It judges the result by reading back the interrupt and status registers: the event's bits, the master flag and the previous errors must all be present.

// File: rtl/flash_irq_pkg.sv
package flash_irq_pkg;

    localparam int DATA_W     = 16;
    localparam int ADDR_W     = 3;
    localparam int N_EVT      = 4;

    localparam int MASTER_BIT = DATA_W - 1;
    localparam int DONE_LSB   = 4;
    localparam int ERR_LSB    = 10;
    localparam int POL_BIT    = 6;
    localparam int RDY_BIT    = 7;

    localparam logic [DATA_W-1:0] CFG1_RST     = 16'h40C0;
    localparam logic [DATA_W-1:0] CFG2_RST     = 16'h0000;
    localparam logic [DATA_W-1:0] CFG1_RD_MASK = 16'hFFE0;

    localparam logic [N_EVT-1:0] DONE_COLD = 4'b1000;
    localparam logic [N_EVT-1:0] DONE_WARM = 4'b0001;

    typedef enum logic [ADDR_W-1:0] {
        RA_STATUS = 3'd0,
        RA_INTR   = 3'd1,
        RA_CFG1   = 3'd2,
        RA_CFG2   = 3'd3,
        RA_CMD    = 3'd4
    } reg_addr_e;

    typedef enum logic {
        ST_ARMED   = 1'b0,
        ST_FLAGGED = 1'b1
    } irq_state_e;

endpackage

// File: rtl/flash_irq_fsm.sv
module flash_irq_fsm
    import flash_irq_pkg::*;
(
    input  logic clk_i,
    input  logic rst_ni,
    input  logic warm_rst_i,
    input  logic intr_wr_i,
    input  logic wr_master_i,
    input  logic any_evt_i,
    output logic master_o
);

    irq_state_e state_q;
    irq_state_e state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_ARMED: begin
                if (warm_rst_i || any_evt_i) begin
                    state_d = ST_FLAGGED;            // FLAG_ON_EVENT
                end
            end
            ST_FLAGGED: begin
                if (warm_rst_i || any_evt_i) begin
                    state_d = ST_FLAGGED;            // FLAG_ON_EVENT
                end else if (intr_wr_i && !wr_master_i) begin
                    state_d = ST_ARMED;              // CLEAR_BY_WRITE
                end
            end
            default: state_d = ST_FLAGGED;
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            state_q <= ST_FLAGGED;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        master_o = (state_q == ST_FLAGGED);
    end

    AST_EVT_FLAGS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        any_evt_i |=> master_o); // R6

    AST_WARM_FLAGS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        warm_rst_i |=> master_o); // R2

endmodule

// File: rtl/flash_irq_regs.sv
module flash_irq_regs
    import flash_irq_pkg::*;
(
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              warm_rst_i,
    input  logic              bus_wr_i,
    input  logic [ADDR_W-1:0] bus_addr_i,
    input  logic [DATA_W-1:0] bus_wdata_i,
    input  logic [N_EVT-1:0]  ev_done_i,
    input  logic              ev_err_i,
    input  logic              ev_unknown_i,
    input  logic              master_i,
    output logic              any_evt_o,
    output logic              intr_wr_o,
    output logic [N_EVT-1:0]  done_o,
    output logic [N_EVT-1:0]  err_o,
    output logic [DATA_W-1:0] cfg1_o,
    output logic [DATA_W-1:0] cfg2_o,
    output logic              ready_o,
    output logic              cmd_valid_o,
    output logic [DATA_W-1:0] cmd_code_o
);

    logic              wr_intr, wr_cfg1, wr_cfg2, wr_cmd;
    logic              clr_errs;
    logic              cmd_take;
    logic [N_EVT-1:0]  err_set;
    logic [N_EVT-1:0]  done_d, err_d;
    logic [N_EVT-1:0]  done_q, err_q;
    logic [DATA_W-1:0] cfg1_q, cfg2_q, cmd_q;
    logic              rdy_q, cval_q;

    assign wr_intr   = bus_wr_i && (bus_addr_i == RA_INTR);
    assign wr_cfg1   = bus_wr_i && (bus_addr_i == RA_CFG1);
    assign wr_cfg2   = bus_wr_i && (bus_addr_i == RA_CFG2);
    assign wr_cmd    = bus_wr_i && (bus_addr_i == RA_CMD);
    assign any_evt_o = (|ev_done_i) || ev_unknown_i;
    assign intr_wr_o = wr_intr;

    // the generic command error accompanies every failure
    assign err_set[0] = ev_unknown_i || (ev_err_i && (|ev_done_i));
    for (genvar g = 1; g < N_EVT; g++) begin : g_err_set
        assign err_set[g] = ev_err_i && ev_done_i[g];
    end

    // master ends clear only when the write drops it and no event raises it
    assign clr_errs = wr_intr && !(master_i && bus_wdata_i[MASTER_BIT]) && !any_evt_o;
    assign cmd_take = wr_cmd && !master_i && !warm_rst_i;

    always_comb begin
        if (warm_rst_i) begin
            done_d = DONE_WARM;
            err_d  = '0;
        end else begin
            done_d = (wr_intr ? (done_q & bus_wdata_i[DONE_LSB +: N_EVT]) : done_q)
                     | ev_done_i;
            err_d  = (clr_errs ? '0 : err_q) | err_set;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            done_q <= DONE_COLD;
            err_q  <= '0;
        end else begin
            done_q <= done_d;
            err_q  <= err_d;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            cfg1_q <= CFG1_RST;
            cfg2_q <= CFG2_RST;
            rdy_q  <= 1'b1;
        end else if (warm_rst_i) begin
            cfg1_q <= CFG1_RST;
            cfg2_q <= CFG2_RST;
            rdy_q  <= 1'b1;
        end else begin
            if (wr_cfg1) begin
                cfg1_q <= bus_wdata_i;
                rdy_q  <= bus_wdata_i[RDY_BIT];
            end
            if (wr_cfg2) begin
                cfg2_q <= bus_wdata_i;
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            cmd_q  <= '0;
            cval_q <= 1'b0;
        end else begin
            cval_q <= cmd_take;
            if (cmd_take) begin
                cmd_q <= bus_wdata_i;
            end
        end
    end

    assign done_o      = done_q;
    assign err_o       = err_q;
    assign cfg1_o      = cfg1_q;
    assign cfg2_o      = cfg2_q;
    assign ready_o     = rdy_q;
    assign cmd_valid_o = cval_q;
    assign cmd_code_o  = cmd_q;

    AST_ERR_PAIR: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (|err_q[N_EVT-1:1]) |-> err_q[0]); // R3

    AST_CMD_REFUSED: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wr_cmd && master_i) |=> (!cval_q && $stable(cmd_q))); // R9

    AST_WARM_VALUES: assert property (@(posedge clk_i) disable iff (!rst_ni)
        warm_rst_i |=> (done_q == DONE_WARM && err_q == '0 && rdy_q)); // R2

    AST_READY_FOLLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wr_cfg1 && !warm_rst_i) |=> (rdy_q == $past(bus_wdata_i[RDY_BIT]))); // R8

    AST_EVT_DONE_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (|ev_done_i && !warm_rst_i) |=> ((done_q & $past(ev_done_i)) == $past(ev_done_i))); // R6

endmodule

// File: rtl/flash_irq_rdmux.sv
module flash_irq_rdmux
    import flash_irq_pkg::*;
(
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              master_i,
    input  logic [N_EVT-1:0]  done_i,
    input  logic [N_EVT-1:0]  err_i,
    input  logic [DATA_W-1:0] cfg1_i,
    input  logic [DATA_W-1:0] cfg2_i,
    input  logic [DATA_W-1:0] cmd_i,
    output logic [DATA_W-1:0] rdata_o
);

    logic [DATA_W-1:0] intr_word;
    logic [DATA_W-1:0] stat_word;

    always_comb begin
        intr_word                       = '0;
        intr_word[MASTER_BIT]           = master_i;
        intr_word[DONE_LSB +: N_EVT]    = done_i;
        stat_word                       = '0;
        stat_word[ERR_LSB +: N_EVT]     = err_i;
    end

    always_comb begin
        unique case (addr_i)
            RA_STATUS: rdata_o = stat_word;
            RA_INTR:   rdata_o = intr_word;
            RA_CFG1:   rdata_o = cfg1_i & CFG1_RD_MASK;
            RA_CFG2:   rdata_o = cfg2_i;
            RA_CMD:    rdata_o = cmd_i;
            default:   rdata_o = '0;
        endcase
    end

endmodule

// File: rtl/flash_irq_ctrl.sv
module flash_irq_ctrl
    import flash_irq_pkg::*;
(
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              warm_rst_i,
    input  logic              bus_wr_i,
    input  logic [ADDR_W-1:0] bus_addr_i,
    input  logic [DATA_W-1:0] bus_wdata_i,
    output logic [DATA_W-1:0] bus_rdata_o,
    input  logic [N_EVT-1:0]  ev_done_i,
    input  logic              ev_err_i,
    input  logic              ev_unknown_i,
    output logic              irq_o,
    output logic              ready_o,
    output logic              cmd_valid_o,
    output logic [DATA_W-1:0] cmd_code_o
);

    logic              master;
    logic              any_evt;
    logic              intr_wr;
    logic [N_EVT-1:0]  done;
    logic [N_EVT-1:0]  err;
    logic [DATA_W-1:0] cfg1;
    logic [DATA_W-1:0] cfg2;

    flash_irq_fsm u_fsm (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .warm_rst_i  (warm_rst_i),
        .intr_wr_i   (intr_wr),
        .wr_master_i (bus_wdata_i[MASTER_BIT]),
        .any_evt_i   (any_evt),
        .master_o    (master)
    );

    flash_irq_regs u_regs (
        .clk_i        (clk_i),
        .rst_ni       (rst_ni),
        .warm_rst_i   (warm_rst_i),
        .bus_wr_i     (bus_wr_i),
        .bus_addr_i   (bus_addr_i),
        .bus_wdata_i  (bus_wdata_i),
        .ev_done_i    (ev_done_i),
        .ev_err_i     (ev_err_i),
        .ev_unknown_i (ev_unknown_i),
        .master_i     (master),
        .any_evt_o    (any_evt),
        .intr_wr_o    (intr_wr),
        .done_o       (done),
        .err_o        (err),
        .cfg1_o       (cfg1),
        .cfg2_o       (cfg2),
        .ready_o      (ready_o),
        .cmd_valid_o  (cmd_valid_o),
        .cmd_code_o   (cmd_code_o)
    );

    flash_irq_rdmux u_rdmux (
        .addr_i  (bus_addr_i),
        .master_i(master),
        .done_i  (done),
        .err_i   (err),
        .cfg1_i  (cfg1),
        .cfg2_i  (cfg2),
        .cmd_i   (cmd_code_o),
        .rdata_o (bus_rdata_o)
    );

    assign irq_o = master ^ ~cfg1[POL_BIT];

    AST_CLEAN_ARMED: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !master |-> (err == '0)); // R5

    AST_UNKNOWN_FLAGS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (ev_unknown_i && !warm_rst_i) |=> (master && err[0])); // R4

    AST_STROBE_ONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        cmd_valid_o |-> $past(bus_wr_i && bus_addr_i == RA_CMD)); // R9

endmodule

// File: tb/flash_irq_ctrl_tb.sv
module flash_irq_ctrl_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 200000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        warm = 1'b0;
    logic        wr = 1'b0;
    logic [2:0]  addr = 3'd0;
    logic [15:0] wdata = 16'h0;
    logic [15:0] rdata;
    logic [3:0]  ev_done = 4'h0;
    logic        ev_err = 1'b0;
    logic        ev_unk = 1'b0;
    logic        irq, ready, cval;
    logic [15:0] ccode;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    flash_irq_ctrl dut_i (
        .clk_i(clk), .rst_ni(rst_n), .warm_rst_i(warm),
        .bus_wr_i(wr), .bus_addr_i(addr), .bus_wdata_i(wdata), .bus_rdata_o(rdata),
        .ev_done_i(ev_done), .ev_err_i(ev_err), .ev_unknown_i(ev_unk),
        .irq_o(irq), .ready_o(ready), .cmd_valid_o(cval), .cmd_code_o(ccode)
    );

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic rd(input logic [2:0] a, output logic [15:0] v);
        addr = a;
        #1;
        v = rdata;
    endtask

    task automatic chk_reg(input string req, input logic [2:0] a, input logic [15:0] exp);
        logic [15:0] v;
        rd(a, v);
        check(req, v, exp);
    endtask

    // one edge with a write and optional events together
    task automatic step(input logic do_wr, input logic [2:0] a, input logic [15:0] d,
                        input logic [3:0] done, input logic err, input logic unk);
        wr = do_wr; addr = a; wdata = d;
        ev_done = done; ev_err = err; ev_unk = unk;
        @(posedge clk);
        @(negedge clk);
        wr = 1'b0; ev_done = 4'h0; ev_err = 1'b0; ev_unk = 1'b0;
    endtask

    task automatic wreg(input logic [2:0] a, input logic [15:0] d);
        step(1'b1, a, d, 4'h0, 1'b0, 1'b0);
    endtask

    task automatic evt(input logic [3:0] done, input logic err, input logic unk);
        step(1'b0, 3'd0, 16'h0, done, err, unk);
    endtask

    task automatic summary;
        if (!finished) begin
            finished = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog actual=%h expected=%h", 16'h0, 16'h1);
        summary();
    end

    initial begin
        logic [15:0] v, exp_st, w, c1;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 cold reset values
        chk_reg("R1 intr", 3'd1, 16'h8080);
        chk_reg("R1 status", 3'd0, 16'h0000);
        chk_reg("R1 cfg1", 3'd2, 16'h40C0);
        chk_reg("R1 cfg2", 3'd3, 16'h0000);
        check("R1 ready", {15'h0, ready}, 16'h1);
        check("R1 cmd_valid", {15'h0, cval}, 16'h0);
        check("R7 irq after reset", {15'h0, irq}, 16'h1);

        // R9 command refused while master set
        wreg(3'd4, 16'h0031);
        check("R9 refused strobe", {15'h0, cval}, 16'h0);
        chk_reg("R9 refused code", 3'd4, 16'h0000);

        // R5 clear master, then R9 accepted command
        wreg(3'd1, 16'h0000);
        chk_reg("R5 intr cleared", 3'd1, 16'h0000);
        check("R7 irq low", {15'h0, irq}, 16'h0);
        wreg(3'd4, 16'h00A5);
        check("R9 accept strobe", {15'h0, cval}, 16'h1);
        check("R9 accept code", ccode, 16'h00A5);
        @(negedge clk);
        check("R9 strobe single", {15'h0, cval}, 16'h0);
        chk_reg("R9 readback", 3'd4, 16'h00A5);

        // R3 / R5 sweep over each completion kind with and without error
        for (int i = 0; i < 4; i++) begin
            for (int e = 0; e < 2; e++) begin
                evt(4'(1 << i), e[0], 1'b0);
                exp_st = (e == 1) ? (16'h0400 | ((i > 0) ? 16'(1 << (10 + i)) : 16'h0)) : 16'h0;
                chk_reg("R3 intr bits", 3'd1, 16'h8000 | 16'(1 << (4 + i)));
                chk_reg("R3 status bits", 3'd0, exp_st);
                wreg(3'd1, 16'h8000);
                chk_reg("R5 and keeps master", 3'd1, 16'h8000);
                chk_reg("R5 errors kept", 3'd0, exp_st);
                wreg(3'd1, 16'h0000);
                chk_reg("R5 errors wiped", 3'd0, 16'h0000);
            end
        end

        // R4 unknown command
        evt(4'h0, 1'b0, 1'b1);
        chk_reg("R4 intr", 3'd1, 16'h8000);
        chk_reg("R4 status", 3'd0, 16'h0400);
        wreg(3'd4, 16'h0077);
        check("R9 refused after unknown", {15'h0, cval}, 16'h0);
        chk_reg("R9 code kept", 3'd4, 16'h00A5);
        wreg(3'd1, 16'h0000);

        // R5 AND sweep over all completion-bit masks
        for (int m = 0; m < 16; m++) begin
            evt(4'hF, 1'b0, 1'b0);
            w = 16'h8000 | 16'(m << 4) | 16'h0F0F;
            wreg(3'd1, w);
            chk_reg("R5 and mask", 3'd1, 16'h8000 | 16'(m << 4));
        end
        wreg(3'd1, 16'h0000);

        // R6 event and clearing write in the same cycle
        step(1'b1, 3'd1, 16'h0000, 4'b0100, 1'b1, 1'b0);
        chk_reg("R6 intr survives", 3'd1, 16'h8040);
        chk_reg("R6 status survives", 3'd0, 16'h1400);
        step(1'b1, 3'd1, 16'h0000, 4'b0001, 1'b0, 1'b0);
        chk_reg("R6 new bit only", 3'd1, 16'h8010);
        chk_reg("R6 old errors kept", 3'd0, 16'h1400);
        wreg(3'd1, 16'h0000);
        chk_reg("R5 final clear", 3'd0, 16'h0000);

        // R7 polarity x master sweep, R8 ready
        for (int mst = 0; mst < 2; mst++) begin
            for (int p = 0; p < 4; p++) begin
                if (mst == 1) evt(4'b0010, 1'b0, 1'b0);
                c1 = 16'h1200 | 16'(p[0] << 6) | 16'(p[1] << 7);
                wreg(3'd2, c1);
                check("R7 irq", {15'h0, irq}, {15'h0, mst[0] ^ ~p[0]});
                check("R8 ready", {15'h0, ready}, {15'h0, p[1]});
                wreg(3'd1, 16'h0000);
                check("R7 irq after clear", {15'h0, irq}, {15'h0, ~p[0]});
            end
        end

        // R8 readback masks
        for (int k = 0; k < 32; k++) begin
            c1 = 16'(k * 16'h0813) ^ 16'h5A5A;
            wreg(3'd2, c1);
            chk_reg("R8 cfg1 mask", 3'd2, c1 & 16'hFFE0);
            check("R8 ready bit", {15'h0, ready}, {15'h0, c1[7]});
            wreg(3'd3, ~c1);
            chk_reg("R8 cfg2", 3'd3, ~c1);
        end

        // R10 status read-only and unmapped addresses
        evt(4'b1000, 1'b1, 1'b0);
        wreg(3'd0, 16'h0000);
        chk_reg("R10 status unchanged", 3'd0, 16'h2400);
        wreg(3'd0, 16'hFFFF);
        chk_reg("R10 status unchanged", 3'd0, 16'h2400);
        for (int a = 5; a < 8; a++) begin
            wreg(3'(a), 16'hFFFF);
            chk_reg("R10 unmapped", 3'(a), 16'h0000);
        end

        // R2 warm reset, with a competing write and event
        wreg(3'd2, 16'h0000);
        wreg(3'd3, 16'h1234);
        warm = 1'b1;
        step(1'b1, 3'd2, 16'hFFFF, 4'b0100, 1'b1, 1'b0);
        warm = 1'b0;
        chk_reg("R2 intr", 3'd1, 16'h8010);
        chk_reg("R2 status", 3'd0, 16'h0000);
        chk_reg("R2 cfg1", 3'd2, 16'h40C0);
        chk_reg("R2 cfg2", 3'd3, 16'h0000);
        check("R2 ready", {15'h0, ready}, 16'h1);

        summary();
    end

endmodule